// File: doc/BRIEF.md
# ATA Device Task-File Register Block

This block is the register face of an ATA or ATAPI storage device. A host-side controller reaches it through a flat register port: a 4-bit address, a write enable, 16-bit write data and a combinational 16-bit read path. The block stores the shadow registers that the host uses to describe a command. These are the error/features pair, sector count, sector number, both cylinder bytes, device/head, the command/status pair and the alternate-status/device-control pair.

A small state machine follows the soft-reset bit in device control. It has two states. READY is the normal state. SELFTEST is entered while the soft-reset bit is held high. Two transitions exist. ENTER_SELFTEST fires on a device-control write that raises the bit: busy is set and the diagnostic code is loaded. LEAVE_SELFTEST fires on a write that lowers the bit: the protocol signature is loaded, the diagnostic result is reported and busy is released. The device type and the device number (0 or 1) are strap inputs. A hard reset performs both phases at once. A command write that passes the selection gate raises a one-cycle strobe toward a separate command executor.

Top module: `ata_taskfile_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads: error 0x01, sector count 1, sector number 1, device/head 0, and no strobe. `pdiag` goes low. The cylinder and status registers take the signature of R5 or R6, chosen by `atapi_mode`. The status value saved for later restore is 0x50.
- R2: A write to address 14 with wdata bit 2 = 1, while the state is READY, moves the state to SELFTEST. After that clock edge, status bit 7 (busy) is 1, error is 0x01 and `pdiag` is 0.
- R3: A write to address 14 whose bit 2 equals the current soft-reset state starts no reset action. Error, status, sector count and the other registers keep their values.
- R4: A write to address 14 with bit 2 = 0, while the state is SELFTEST, returns the state to READY. In the same edge it loads sector count 1, sector number 1 and device/head 0, and it clears status bit 7.
- R5: The ATA signature (`atapi_mode` = 0) puts 0x00 in both cylinder registers and sets status to 0x50. This is bit 6 (ready) together with bit 4 (seek complete).
- R6: The ATAPI signature (`atapi_mode` = 1) puts 0x14 in cylinder low and 0xEB in cylinder high, and forces status to 0x00. The previous status, with bit 7 cleared, is kept for restore.
- R7: When R4 runs on device 0 (`dev_id` = 0) with `dev1_present` = 1, error bit 7 is also set. Error then reads 0x81.
- R8: When R4 runs on device 1 and error equals 0x01, `pdiag` is driven high. It stays high until the next R2 or R1.
- R9: A write to address 7 latches wdata[7:0] onto `cmd_code`. If device/head bit 4 equals `dev_id`, `cmd_strobe` is high for exactly the one cycle after that write's clock edge.
- R10: The command 0x90 (execute device diagnostic) strobes whatever the selection. Any other command written while device/head bit 4 differs from `dev_id` gives no strobe.
- R11: The first strobed command after an ATAPI signature load sets status to the saved value. Later commands leave status unchanged.
- R12: The address map is 0 data, 1 error (read) / features (write, on `feat_code`), 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 device/head, 7 status (read) / command (write), and 14 alternate status (read) / device control (write). Registers 2 to 6 read back the low byte last written. Address 0 reads 0xFFFF. Addresses 7 and 14 both read status. Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| dev_id | input | 1 | Strapped device number (0 or 1) |
| dev1_present | input | 1 | Device 1 is attached (read by device 0) |
| atapi_mode | input | 1 | 1 = packet device signature, 0 = ATA signature |
| wr_en | input | 1 | Register write enable |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data (low byte used) |
| rdata | output | 16 | Combinational read data for `addr` |
| cmd_strobe | output | 1 | One-cycle pulse: accepted command |
| cmd_code | output | 8 | Last command byte written |
| feat_code | output | 8 | Last features byte written |
| pdiag | output | 1 | Device 1 diagnostic pass indication |

## Verification
The hardest situation to reach is the deferred status restore of an ATAPI device. It needs a hard or soft reset in ATAPI mode, then a command that passes the selection gate. The restored value also depends on the status held at the moment the soft-reset bit fell. Directed sequences build this chain explicitly, including a restore followed by a second command. The random phase mixes device-control writes with repeated soft-reset bit values, selection changes and diagnostic commands. It re-straps the device between hard resets, so that R3, R7 and R11 meet many different prior states.

// File: rtl/tf_pkg.sv
package tf_pkg;
    localparam int TF_AW = 4;
    localparam int TF_RW = 8;

    localparam logic [TF_AW-1:0] A_DATA    = 4'd0;
    localparam logic [TF_AW-1:0] A_ERRFEAT = 4'd1;
    localparam logic [TF_AW-1:0] A_SCNT    = 4'd2;
    localparam logic [TF_AW-1:0] A_SNUM    = 4'd3;
    localparam logic [TF_AW-1:0] A_CYLL    = 4'd4;
    localparam logic [TF_AW-1:0] A_CYLH    = 4'd5;
    localparam logic [TF_AW-1:0] A_DEVHD   = 4'd6;
    localparam logic [TF_AW-1:0] A_STATCMD = 4'd7;
    localparam logic [TF_AW-1:0] A_ALTCTL  = 4'd14;

    localparam int BIT_BSY  = 7;
    localparam int BIT_SRST = 2;
    localparam int BIT_DEV  = 4;

    localparam logic [TF_RW-1:0] ST_ATA_OK  = 8'h50;
    localparam logic [TF_RW-1:0] DIAG_CODE  = 8'h01;
    localparam logic [TF_RW-1:0] DIAG_DEV1F = 8'h80;
    localparam logic [TF_RW-1:0] CMD_DIAG   = 8'h90;
    localparam logic [TF_RW-1:0] SIG_PKT_LO = 8'h14;
    localparam logic [TF_RW-1:0] SIG_PKT_HI = 8'hEB;

    typedef enum logic {
        RS_READY    = 1'b0,
        RS_SELFTEST = 1'b1
    } rst_state_e;
endpackage

// File: rtl/tf_srst_fsm.sv
module tf_srst_fsm
    import tf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic srst_in,
    output logic go_selftest,
    output logic go_signature,
    output logic in_selftest
);
    rst_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_READY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d         = st_q;
        go_selftest  = 1'b0;
        go_signature = 1'b0;
        unique case (st_q)
            RS_READY: begin
                if (ctl_wr && srst_in) begin
                    st_d        = RS_SELFTEST;
                    go_selftest = 1'b1;
                end
            end
            RS_SELFTEST: begin
                if (ctl_wr && !srst_in) begin
                    st_d         = RS_READY;
                    go_signature = 1'b1;
                end
            end
        endcase
    end

    assign in_selftest = (st_q == RS_SELFTEST);
endmodule

// File: rtl/tf_rd_mux.sv
module tf_rd_mux
    import tf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [TF_AW-1:0] addr,
    input  logic [TF_RW-1:0] err,
    input  logic [TF_RW-1:0] scnt,
    input  logic [TF_RW-1:0] snum,
    input  logic [TF_RW-1:0] cyll,
    input  logic [TF_RW-1:0] cylh,
    input  logic [TF_RW-1:0] devhd,
    input  logic [TF_RW-1:0] stat,
    output logic [DW-1:0]    rdata
);
    localparam int PAD = DW - TF_RW;

    always_comb begin
        case (addr)
            A_DATA:               rdata = {DW{1'b1}};
            A_ERRFEAT:            rdata = {{PAD{1'b0}}, err};
            A_SCNT:               rdata = {{PAD{1'b0}}, scnt};
            A_SNUM:               rdata = {{PAD{1'b0}}, snum};
            A_CYLL:               rdata = {{PAD{1'b0}}, cyll};
            A_CYLH:               rdata = {{PAD{1'b0}}, cylh};
            A_DEVHD:              rdata = {{PAD{1'b0}}, devhd};
            A_STATCMD, A_ALTCTL:  rdata = {{PAD{1'b0}}, stat};
            default:              rdata = '0;
        endcase
    end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import tf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_id,
    input  logic             dev1_present,
    input  logic             atapi_mode,
    input  logic             wr_en,
    input  logic [TF_AW-1:0] addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             cmd_strobe,
    output logic [TF_RW-1:0] cmd_code,
    output logic [TF_RW-1:0] feat_code,
    output logic             pdiag
);
    localparam logic [TF_RW-1:0] BSY_MASK = TF_RW'(1) << BIT_BSY;

    logic [TF_RW-1:0] err_q, feat_q, scnt_q, snum_q, cyll_q, cylh_q;
    logic [TF_RW-1:0] devhd_q, cmd_q, stat_q, stsave_q;
    logic             restore_q, strobe_q, pdiag_q;
    logic             go_selftest, go_signature, in_selftest;
    logic [TF_RW-1:0] wbyte;
    logic             unused_hi;
    logic             selected, cmd_ok;

    assign wbyte     = wdata[TF_RW-1:0];
    assign unused_hi = ^wdata[DW-1:TF_RW];
    assign selected  = (devhd_q[BIT_DEV] == dev_id);
    assign cmd_ok    = selected || (wbyte == CMD_DIAG);

    tf_srst_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (wr_en && (addr == A_ALTCTL)),
        .srst_in     (wdata[BIT_SRST]),
        .go_selftest (go_selftest),
        .go_signature(go_signature),
        .in_selftest (in_selftest)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= DIAG_CODE;
            feat_q    <= '0;
            scnt_q    <= 8'd1;
            snum_q    <= 8'd1;
            devhd_q   <= '0;
            cmd_q     <= '0;
            cyll_q    <= atapi_mode ? SIG_PKT_LO : 8'h00;
            cylh_q    <= atapi_mode ? SIG_PKT_HI : 8'h00;
            stat_q    <= atapi_mode ? 8'h00 : ST_ATA_OK;
            stsave_q  <= ST_ATA_OK;
            restore_q <= atapi_mode;
            strobe_q  <= 1'b0;
            pdiag_q   <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (go_selftest) begin
                stat_q  <= stat_q | BSY_MASK;
                err_q   <= DIAG_CODE;
                pdiag_q <= 1'b0;
            end
            if (go_signature) begin
                err_q   <= (!dev_id && dev1_present) ? (err_q | DIAG_DEV1F) : err_q;
                scnt_q  <= 8'd1;
                snum_q  <= 8'd1;
                devhd_q <= '0;
                pdiag_q <= dev_id && (err_q == DIAG_CODE);
                if (atapi_mode) begin
                    cyll_q    <= SIG_PKT_LO;
                    cylh_q    <= SIG_PKT_HI;
                    stsave_q  <= stat_q & ~BSY_MASK;
                    stat_q    <= 8'h00;
                    restore_q <= 1'b1;
                end else begin
                    cyll_q <= 8'h00;
                    cylh_q <= 8'h00;
                    stat_q <= ST_ATA_OK;
                end
            end
            if (wr_en) begin
                case (addr)
                    A_ERRFEAT: feat_q  <= wbyte;
                    A_SCNT:    scnt_q  <= wbyte;
                    A_SNUM:    snum_q  <= wbyte;
                    A_CYLL:    cyll_q  <= wbyte;
                    A_CYLH:    cylh_q  <= wbyte;
                    A_DEVHD:   devhd_q <= wbyte;
                    A_STATCMD: begin
                        cmd_q <= wbyte;
                        if (cmd_ok) begin
                            strobe_q <= 1'b1;
                            if (restore_q) begin
                                stat_q    <= stsave_q;
                                restore_q <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    tf_rd_mux #(.DW(DW)) u_rd (
        .addr (addr),
        .err  (err_q),
        .scnt (scnt_q),
        .snum (snum_q),
        .cyll (cyll_q),
        .cylh (cylh_q),
        .devhd(devhd_q),
        .stat (stat_q),
        .rdata(rdata)
    );

    assign cmd_strobe = strobe_q;
    assign cmd_code   = cmd_q;
    assign feat_code  = feat_q;
    assign pdiag      = pdiag_q;
endmodule

// File: rtl/tf_checker.sv
module tf_checker
    import tf_pkg::*;
#(
    parameter int DW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dev_id,
    input logic             wr_en,
    input logic [TF_AW-1:0] addr,
    input logic [DW-1:0]    wdata,
    input logic [TF_RW-1:0] stat,
    input logic [TF_RW-1:0] err,
    input logic [TF_RW-1:0] devhd,
    input logic             in_st,
    input logic             cmd_strobe,
    input logic             pdiag
);
    AST_RISE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ALTCTL && wdata[BIT_SRST] && !in_st)
        |=> (stat[BIT_BSY] && err == DIAG_CODE && in_st && !pdiag)); // R2

    AST_FALL_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ALTCTL && !wdata[BIT_SRST] && in_st)
        |=> (!stat[BIT_BSY] && !in_st && devhd == 8'h00)); // R4

    AST_SAME_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_ALTCTL && (wdata[BIT_SRST] == in_st))
        |=> ($stable(err) && $stable(in_st) && $stable(stat))); // R3

    AST_STROBE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> $past(wr_en && addr == A_STATCMD)); // R9

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STATCMD && devhd[BIT_DEV] != dev_id
         && wdata[TF_RW-1:0] != CMD_DIAG) |=> !cmd_strobe); // R10

    AST_PDIAG_DEV1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pdiag |-> dev_id); // R8

    AST_BUSY_IN_SELFTEST: assert property (@(posedge clk) disable iff (!rst_n)
        stat[BIT_BSY] |-> in_st); // R2
endmodule

bind ata_taskfile_regs tf_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_id    (dev_id),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .stat      (stat_q),
    .err       (err_q),
    .devhd     (devhd_q),
    .in_st     (in_selftest),
    .cmd_strobe(cmd_strobe),
    .pdiag     (pdiag)
);

// File: tb/sim_ata_taskfile_regs.sv
`timescale 1ns/1ps
module sim_ata_taskfile_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_id = 1'b0, dev1_present = 1'b0, atapi_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic cmd_strobe, pdiag;
    logic [7:0] cmd_code, feat_code;

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model of the register state
    logic [7:0] e_err, e_sc, e_sn, e_cl, e_ch, e_dh, e_st, e_save, e_cmd, e_feat;
    logic e_rest, e_srst, e_pd, e_sb;

    always #5 clk = ~clk;

    ata_taskfile_regs u0 (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .dev1_present(dev1_present),
        .atapi_mode(atapi_mode), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
        .feat_code(feat_code), .pdiag(pdiag)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic hard(logic d, logic p1, logic pi);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        dev_id = d; dev1_present = p1; atapi_mode = pi;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_err = 8'h01; e_sc = 8'h01; e_sn = 8'h01; e_dh = 8'h00;
        e_cl = pi ? 8'h14 : 8'h00; e_ch = pi ? 8'hEB : 8'h00;
        e_st = pi ? 8'h00 : 8'h50; e_save = 8'h50; e_rest = pi;
        e_srst = 1'b0; e_pd = 1'b0; e_sb = 1'b0; e_cmd = 8'h00; e_feat = 8'h00;
    endtask

    task automatic model_wr(logic [3:0] a, logic [15:0] d);
        e_sb = 1'b0;
        case (a)
            4'd1: e_feat = d[7:0];
            4'd2: e_sc = d[7:0];
            4'd3: e_sn = d[7:0];
            4'd4: e_cl = d[7:0];
            4'd5: e_ch = d[7:0];
            4'd6: e_dh = d[7:0];
            4'd7: begin
                e_cmd = d[7:0];
                if (e_dh[4] == dev_id || d[7:0] == 8'h90) begin
                    e_sb = 1'b1;
                    if (e_rest) begin e_st = e_save; e_rest = 1'b0; end
                end
            end
            4'd14: begin
                if (d[2] && !e_srst) begin
                    e_st[7] = 1'b1; e_err = 8'h01; e_pd = 1'b0;
                end else if (!d[2] && e_srst) begin
                    if (!dev_id && dev1_present) e_err = e_err | 8'h80;
                    e_sc = 8'h01; e_sn = 8'h01; e_dh = 8'h00;
                    if (atapi_mode) begin
                        e_cl = 8'h14; e_ch = 8'hEB;
                        e_save = e_st & 8'h7F; e_st = 8'h00; e_rest = 1'b1;
                    end else begin
                        e_cl = 8'h00; e_ch = 8'h00; e_st = 8'h50;
                    end
                    e_pd = dev_id && (e_err == 8'h01);
                end
                e_srst = d[2];
            end
            default: ;
        endcase
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic check_all(string req);
        logic [15:0] v;
        rd(4'd1, v);  chk(req, "error", v, {8'h00, e_err});
        rd(4'd2, v);  chk(req, "sector count", v, {8'h00, e_sc});
        rd(4'd3, v);  chk(req, "sector number", v, {8'h00, e_sn});
        rd(4'd4, v);  chk(req, "cylinder low", v, {8'h00, e_cl});
        rd(4'd5, v);  chk(req, "cylinder high", v, {8'h00, e_ch});
        rd(4'd6, v);  chk(req, "device/head", v, {8'h00, e_dh});
        rd(4'd7, v);  chk(req, "status", v, {8'h00, e_st});
        rd(4'd14, v); chk(req, "alt status", v, {8'h00, e_st});
        chk(req, "pdiag", {15'd0, pdiag}, {15'd0, e_pd});
        chk(req, "cmd_code", {8'h00, cmd_code}, {8'h00, e_cmd});
        chk(req, "feat_code", {8'h00, feat_code}, {8'h00, e_feat});
    endtask

    task automatic chk_strobe(string req);
        chk(req, "cmd_strobe", {15'd0, cmd_strobe}, {15'd0, e_sb});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5EED_0A7A));

        // R1 reset state, ATA device 0
        hard(1'b0, 1'b0, 1'b0);
        check_all("R1");
        rd(4'd7, v); chk("R1", "ATA status literal", v, 16'h0050);
        chk("R1", "no strobe", {15'd0, cmd_strobe}, 16'd0);

        // R12 address map corners
        rd(4'd0, v);  chk("R12", "data read", v, 16'hFFFF);
        rd(4'd9, v);  chk("R12", "unknown read", v, 16'h0000);
        wr(4'd9, 16'h00AA); check_all("R12");
        wr(4'd1, 16'h1234); check_all("R12");
        rd(4'd1, v);  chk("R12", "features not on error", v, 16'h0001);

        // R2 soft reset rise
        wr(4'd14, 16'h0004);
        rd(4'd7, v); chk("R2", "busy status", v, 16'h00D0);
        check_all("R2");
        // R3 repeated SRST=1 changes nothing
        wr(4'd2, 16'h0033);
        wr(4'd14, 16'h0006);
        rd(4'd2, v); chk("R3", "sector count kept", v, 16'h0033);
        check_all("R3");
        // R4 and R5 fall: signature
        wr(4'd14, 16'h0000);
        rd(4'd2, v); chk("R4", "sector count sig", v, 16'h0001);
        rd(4'd7, v); chk("R5", "ATA status", v, 16'h0050);
        check_all("R5");
        // R3 repeated SRST=0 loads nothing
        wr(4'd3, 16'h0077);
        wr(4'd14, 16'h0008);
        rd(4'd3, v); chk("R3", "sector number kept", v, 16'h0077);

        // R7 device 0 sees device 1
        hard(1'b0, 1'b1, 1'b0);
        wr(4'd14, 16'h0004); wr(4'd14, 16'h0000);
        rd(4'd1, v); chk("R7", "error with dev1", v, 16'h0081);
        chk("R7", "no pdiag on dev0", {15'd0, pdiag}, 16'd0);

        // R6 R8 R11 ATAPI device 1
        hard(1'b1, 1'b0, 1'b1);
        check_all("R6");
        rd(4'd5, v); chk("R6", "cyl high sig", v, 16'h00EB);
        wr(4'd6, 16'h0010);
        wr(4'd7, 16'h00EC); chk_strobe("R9");
        chk("R9", "cmd_code", {8'h00, cmd_code}, 16'h00EC);
        rd(4'd7, v); chk("R11", "restored status", v, 16'h0050);
        @(negedge clk);
        chk("R9", "strobe one cycle", {15'd0, cmd_strobe}, 16'd0);
        wr(4'd14, 16'h0004); wr(4'd14, 16'h0000);
        chk("R8", "pdiag high", {15'd0, pdiag}, 16'd1);
        rd(4'd7, v); chk("R6", "ATAPI status zero", v, 16'h0000);
        check_all("R8");
        wr(4'd6, 16'h0010);
        wr(4'd7, 16'h00A1); chk_strobe("R11");
        rd(4'd7, v); chk("R11", "status from save", v, 16'h0050);
        wr(4'd7, 16'h00A1);
        rd(4'd7, v); chk("R11", "second command no change", v, 16'h0050);
        wr(4'd6, 16'h0000);
        wr(4'd7, 16'h00EC); chk_strobe("R10");
        chk("R10", "unselected no strobe", {15'd0, cmd_strobe}, 16'd0);
        wr(4'd7, 16'h0090); chk_strobe("R10");
        chk("R10", "diag strobes", {15'd0, cmd_strobe}, 16'd1);
        wr(4'd14, 16'h0004);
        chk("R2", "pdiag cleared", {15'd0, pdiag}, 16'd0);

        // random phase
        for (int it = 0; it < 400; it++) begin
            logic [3:0] a;
            logic [15:0] d;
            int pick;
            if (it % 80 == 0)
                hard(1'($urandom), 1'($urandom), 1'($urandom));
            pick = int'($urandom_range(0, 9));
            case (pick)
                0: a = 4'd14;
                1: a = 4'd14;
                2: a = 4'd7;
                3: a = 4'd7;
                4: a = 4'd6;
                5: a = 4'($urandom_range(1, 5));
                6: a = 4'($urandom_range(8, 13));
                default: a = 4'($urandom_range(0, 15));
            endcase
            d = 16'($urandom);
            if (a == 4'd7 && $urandom_range(0, 3) == 0) d[7:0] = 8'h90;
            wr(a, d);
            chk_strobe("R10");
            check_all("R12");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule